// File: doc/BRIEF.md
# NAND Prefetch and Post-Write Byte Pump

This block moves a software-programmed number of bytes between a NAND chip-select data port and a 64-byte internal FIFO. Software fills in two setup words: one for the chip select, the FIFO threshold, the enable, the request routing and the direction, and one for the byte total. It then writes a start command. In read (prefetch) direction the engine pulls bytes from the device ahead of the consumer. In write (post-write) direction it drains bytes that the host has pushed into the FIFO out to the device.

The device side is a byte-wide request/acknowledge handshake. Every cycle in which the request and the acknowledge are both high moves one byte and lowers the remaining count by one. On the host side, a push/pop FIFO port serves the CPU or a DMA engine. A threshold comparison on the FIFO occupancy raises either a DMA request or a CPU interrupt-style flag, chosen by one setup bit.

Setup words are locked while a transfer runs. A stop, and the stop-and-clear variant, are honoured only when they name the chip select held in the setup word. When the count runs out, the engine drops its run bit and leaves a sticky done flag, which software clears by writing 1 to it.

Top module: `nand_pump`

## Requirements
- R1: Register 0 (setup) holds the chip select in bits 26:24, the threshold in bits 14:8, the enable in bit 7, the routing in bit 2 (1 = DMA) and the direction in bit 0 (1 = write). It reads back with the same layout. Register 1 holds the byte total in bits 13:0.
- R2: While the engine runs, writes to registers 0 and 1 have no effect.
- R3: Writing register 2 with bit 0 = 1 while idle and enabled sets run, loads the remaining count from the total, and empties the FIFO. A start given while the enable bit is 0 is ignored. Register 2 reads back run in bit 0.
- R4: Writing register 2 with bit 0 = 0 stops the engine, zeroes the remaining count and empties the FIFO, but only when bits 26:24 of the written word equal the held chip select. If bit 1 is also set, the setup word is cleared to zero. A stop that names another chip select is ignored.
- R5: Register 3 reports the FIFO fill in bits 6:0, the remaining count in bits 21:8, run in bit 30 and done in bit 31. All of them are zero after reset.
- R6: In read direction, dev_req is high when the engine runs, the remaining count is nonzero and the FIFO is not full, with dev_we low. Each accepted handshake stores dev_rdata in the FIFO and counts down by one.
- R7: In write direction, dev_req is high when the engine runs, the remaining count is nonzero and the FIFO is not empty. dev_we is high and dev_wdata shows the oldest FIFO byte. Each accepted handshake removes that byte and counts down by one.
- R8: A threshold field of 0, or of more than 64, acts as 64. In read direction the request is high when the fill is at least the threshold, or when the remaining count is zero and the FIFO still holds bytes. In write direction it is high when the engine runs and the free space is at least the threshold.
- R9: The request appears on dma_req when the routing bit is 1 and on cpu_irq when it is 0. The two are never high together.
- R10: One cycle after the engine is seen running with a zero remaining count, run is 0 and done is 1. Done stays set until register 3 is written with bit 31 = 1.
- R11: Host pops take effect only in read direction with a non-empty FIFO. Host pushes take effect only in write direction while running with a non-full FIFO. All other pushes and pops are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 setup, 1 total, 2 command, 3 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| dev_req | output | 1 | Device byte transfer request |
| dev_ack | input | 1 | Device accepts the byte transfer this cycle |
| dev_we | output | 1 | Transfer direction toward the device |
| dev_cs | output | 3 | Selected chip select |
| dev_wdata | output | 8 | Byte sent to the device |
| dev_rdata | input | 8 | Byte returned by the device |
| host_push | input | 1 | Host pushes a byte (write direction) |
| host_wdata | input | 8 | Byte pushed by the host |
| host_pop | input | 1 | Host pops a byte (read direction) |
| host_rdata | output | 8 | Oldest FIFO byte |
| dma_req | output | 1 | Threshold request, DMA routing |
| cpu_irq | output | 1 | Threshold request, CPU routing |

## Verification
The assertions check the following on every cycle: the two request outputs never fire together, a device request implies a running engine with bytes left, the fill never exceeds the FIFO depth, a locked setup word does not change under a write, a valid start raises run, and a count that has run out ends in done. Only the bench scenarios can show the rest. That covers the byte order through the FIFO in both directions, the threshold and tail behaviour of the request, the rejection of a stop that names the wrong chip select, and the clearing variant of stop. It also covers the ignored host pushes and pops, including pushes into a full FIFO. A behavioural queue model is compared against the outputs and the register readback on every clock.

// File: rtl/nand_pump_pkg.sv
package nand_pump_pkg;

    typedef enum logic [1:0] {
        A_SETUP  = 2'd0,
        A_TOTAL  = 2'd1,
        A_CMD    = 2'd2,
        A_STATUS = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [2:0] cs;
        logic [6:0] thr;
        logic       en;
        logic       dma;
        logic       wr_dir;
    } setup_t;

    localparam int CS_LSB    = 24;
    localparam int THR_LSB   = 8;
    localparam int EN_BIT    = 7;
    localparam int DMA_BIT   = 2;
    localparam int DIR_BIT   = 0;
    localparam int CLR_BIT   = 1;
    localparam int REM_LSB   = 8;
    localparam int RUN_BIT   = 30;
    localparam int DONE_BIT  = 31;

    function automatic setup_t setup_unpack(input logic [31:0] w);
        setup_t s;
        s.cs     = w[CS_LSB +: 3];
        s.thr    = w[THR_LSB +: 7];
        s.en     = w[EN_BIT];
        s.dma    = w[DMA_BIT];
        s.wr_dir = w[DIR_BIT];
        return s;
    endfunction

    function automatic logic [31:0] setup_pack(input setup_t s);
        logic [31:0] w;
        w = '0;
        w[CS_LSB +: 3]  = s.cs;
        w[THR_LSB +: 7] = s.thr;
        w[EN_BIT]       = s.en;
        w[DMA_BIT]      = s.dma;
        w[DIR_BIT]      = s.wr_dir;
        return w;
    endfunction

    function automatic int unsigned thr_effective(input logic [6:0] t, input int unsigned depth);
        if (t == 7'd0 || int'(t) > int'(depth))
            return depth;
        return int'(t);
    endfunction

endpackage

// File: rtl/nand_pump_fifo.sv
module nand_pump_fifo #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  fill
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] store [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;

    always_ff @(posedge clk) begin
        if (push)
            store[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push)
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    assign head = store[rd_ptr];

endmodule

// File: rtl/nand_pump_ctrl.sv
module nand_pump_ctrl
    import nand_pump_pkg::*;
#(
    parameter int COUNT_W = 14
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    input  logic               xfer,
    output setup_t             setup,
    output logic [COUNT_W-1:0] total,
    output logic [COUNT_W-1:0] remaining,
    output logic               run,
    output logic               done,
    output logic               flush
);
    logic wr_setup, wr_total, wr_cmd, wr_status;
    logic start_ok, stop_ok, finish;

    always_comb begin
        wr_setup  = reg_wr && reg_addr == A_SETUP;
        wr_total  = reg_wr && reg_addr == A_TOTAL;
        wr_cmd    = reg_wr && reg_addr == A_CMD;
        wr_status = reg_wr && reg_addr == A_STATUS;
        start_ok  = wr_cmd && reg_wdata[0] && !run && setup.en;
        stop_ok   = wr_cmd && !reg_wdata[0] && reg_wdata[CS_LSB +: 3] == setup.cs;
        finish    = run && remaining == '0;
        flush     = start_ok || stop_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            setup     <= '0;
            total     <= '0;
            remaining <= '0;
            run       <= 1'b0;
            done      <= 1'b0;
        end else begin
            if (wr_setup && !run)
                setup <= setup_unpack(reg_wdata);
            if (wr_total && !run)
                total <= reg_wdata[COUNT_W-1:0];

            if (start_ok) begin
                run       <= 1'b1;
                remaining <= total;
            end else if (stop_ok) begin
                run       <= 1'b0;
                remaining <= '0;
                if (reg_wdata[CLR_BIT])
                    setup <= '0;
            end else if (finish) begin
                run <= 1'b0;
            end else if (xfer) begin
                remaining <= remaining - 1'b1;
            end

            if (finish)
                done <= 1'b1;
            else if (wr_status && reg_wdata[DONE_BIT])
                done <= 1'b0;
        end
    end

endmodule

// File: rtl/nand_pump.sv
module nand_pump
    import nand_pump_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int COUNT_W    = 14
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        dev_req,
    input  logic        dev_ack,
    output logic        dev_we,
    output logic [2:0]  dev_cs,
    output logic [7:0]  dev_wdata,
    input  logic [7:0]  dev_rdata,
    input  logic        host_push,
    input  logic [7:0]  host_wdata,
    input  logic        host_pop,
    output logic [7:0]  host_rdata,
    output logic        dma_req,
    output logic        cpu_irq
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(FIFO_DEPTH);

    setup_t             setup_q;
    logic [COUNT_W-1:0] total_q, remaining_q;
    logic               run_q, done_q, flush;
    logic [CNT_W-1:0]   fill, thr;
    logic               empty, full, xfer, f_push, f_pop, want;
    logic [7:0]         f_wdata, head;
    logic [31:0]        setup_word;

    nand_pump_ctrl #(.COUNT_W(COUNT_W)) ctrl_i (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .xfer(xfer),
        .setup(setup_q), .total(total_q), .remaining(remaining_q),
        .run(run_q), .done(done_q), .flush(flush)
    );

    nand_pump_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(8)) fifo_i (
        .clk(clk), .rst(rst), .flush(flush),
        .push(f_push), .push_data(f_wdata),
        .pop(f_pop), .head(head), .fill(fill)
    );

    always_comb begin
        empty   = fill == '0;
        full    = fill == DEPTH_C;
        dev_req = run_q && remaining_q != '0 && (setup_q.wr_dir ? !empty : !full);
        xfer    = dev_req && dev_ack;
        if (setup_q.wr_dir) begin
            f_push  = host_push && run_q && !full;
            f_wdata = host_wdata;
            f_pop   = xfer;
        end else begin
            f_push  = xfer;
            f_wdata = dev_rdata;
            f_pop   = host_pop && !empty;
        end
        thr = CNT_W'(thr_effective(setup_q.thr, FIFO_DEPTH));
        if (setup_q.wr_dir)
            want = run_q && (DEPTH_C - fill) >= thr;
        else
            want = !empty && (fill >= thr || remaining_q == '0);
        dma_req = want && setup_q.dma;
        cpu_irq = want && !setup_q.dma;
    end

    assign dev_we     = setup_q.wr_dir;
    assign dev_cs     = setup_q.cs;
    assign dev_wdata  = head;
    assign host_rdata = head;
    assign setup_word = setup_pack(setup_q);

    always_comb begin
        reg_rdata = '0;
        case (reg_sel_e'(reg_addr))
            A_SETUP:  reg_rdata = setup_word;
            A_TOTAL:  reg_rdata[COUNT_W-1:0] = total_q;
            A_CMD:    reg_rdata[0] = run_q;
            default: begin
                reg_rdata[CNT_W-1:0]           = fill;
                reg_rdata[REM_LSB +: COUNT_W]  = remaining_q;
                reg_rdata[RUN_BIT]             = run_q;
                reg_rdata[DONE_BIT]            = done_q;
            end
        endcase
    end

endmodule

// File: rtl/nand_pump_chk.sv
module nand_pump_chk #(
    parameter int FIFO_DEPTH = 64,
    parameter int COUNT_W    = 14,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               run,
    input logic               done,
    input logic [COUNT_W-1:0] remaining,
    input logic [CNT_W-1:0]   fill,
    input logic               dma_req,
    input logic               cpu_irq,
    input logic               dev_req,
    input logic               reg_wr,
    input logic [1:0]         reg_addr,
    input logic [31:0]        reg_wdata,
    input logic [31:0]        setup_word
);
    // R9
    excl_req_chk: assert property (@(posedge clk) disable iff (rst)
        !(dma_req && cpu_irq));

    // R6
    dev_req_live_chk: assert property (@(posedge clk) disable iff (rst)
        dev_req |-> (run && remaining != '0));

    // R11
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fill <= CNT_W'(FIFO_DEPTH));

    // R2
    busy_setup_chk: assert property (@(posedge clk) disable iff (rst)
        (run && reg_wr && reg_addr == 2'd0) |=> $stable(setup_word));

    // R3
    start_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && reg_wr && reg_addr == 2'd2 && reg_wdata[0] && setup_word[7]) |=> run);

    // R10
    finish_chk: assert property (@(posedge clk) disable iff (rst)
        (run && remaining == '0) |=> (!run && done));

endmodule

bind nand_pump nand_pump_chk #(.FIFO_DEPTH(FIFO_DEPTH), .COUNT_W(COUNT_W)) chk_i (
    .clk(clk), .rst(rst), .run(run_q), .done(done_q), .remaining(remaining_q),
    .fill(fill), .dma_req(dma_req), .cpu_irq(cpu_irq), .dev_req(dev_req),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .setup_word(setup_word)
);

// File: tb/nand_pump_tb_top.sv
module nand_pump_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd3;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dev_req, dev_we, dev_ack = 1'b0;
    logic [2:0]  dev_cs;
    logic [7:0]  dev_wdata, dev_rdata = 8'h00;
    logic        host_push = 1'b0, host_pop = 1'b0;
    logic [7:0]  host_wdata = 8'h00, host_rdata;
    logic        dma_req, cpu_irq;

    always #5 clk = ~clk;

    nand_pump dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dev_req(dev_req), .dev_ack(dev_ack), .dev_we(dev_we), .dev_cs(dev_cs),
        .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
        .host_push(host_push), .host_wdata(host_wdata), .host_pop(host_pop),
        .host_rdata(host_rdata), .dma_req(dma_req), .cpu_irq(cpu_irq)
    );

    // behavioural reference state
    int        m_cs, m_thr, m_en, m_dma, m_dir, m_total, m_rem, m_run, m_done;
    logic [7:0] q[$];
    int        total_checks = 0, bad_checks = 0, cyc = 0;
    string     phase = "R5";
    logic      ack_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    function automatic int thr_m();
        if (m_thr == 0 || m_thr > 64) return 64;
        return m_thr;
    endfunction

    function automatic logic devreq_m();
        return m_run != 0 && m_rem != 0 && (m_dir != 0 ? q.size() != 0 : q.size() < 64);
    endfunction

    function automatic logic want_m();
        if (m_dir != 0) return m_run != 0 && (64 - q.size()) >= thr_m();
        return q.size() != 0 && (q.size() >= thr_m() || m_rem == 0);
    endfunction

    function automatic logic [31:0] rdata_m(input logic [1:0] a);
        case (a)
            2'd0: return (m_cs << 24) | (m_thr << 8) | (m_en << 7) | (m_dma << 2) | m_dir;
            2'd1: return 32'(m_total);
            2'd2: return 32'(m_run);
            default: return (m_done << 31) | (m_run << 30) | (m_rem << 8) | q.size();
        endcase
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        total_checks++;
        if (act !== exp) begin
            bad_checks++;
            $display("FAIL %s %s: actual=%0h expected=%0h at cycle %0d", phase, what, act, exp, cyc);
        end
    endtask

    task automatic model_step();
        logic devq, xf, full, empty, start_ok, stop_ok, finish, push, pop;
        logic [7:0] pdata;
        if (rst) begin
            m_cs = 0; m_thr = 0; m_en = 0; m_dma = 0; m_dir = 0;
            m_total = 0; m_rem = 0; m_run = 0; m_done = 0;
            q.delete();
            return;
        end
        devq     = devreq_m();
        xf       = devq && dev_ack;
        full     = q.size() == 64;
        empty    = q.size() == 0;
        start_ok = reg_wr && reg_addr == 2'd2 && reg_wdata[0] && m_run == 0 && m_en != 0;
        stop_ok  = reg_wr && reg_addr == 2'd2 && !reg_wdata[0] && int'(reg_wdata[26:24]) == m_cs;
        finish   = m_run != 0 && m_rem == 0;
        push     = (m_dir != 0) ? (host_push && m_run != 0 && !full) : xf;
        pdata    = (m_dir != 0) ? host_wdata : dev_rdata;
        pop      = (m_dir != 0) ? xf : (host_pop && !empty);
        if (start_ok || stop_ok) q.delete();
        else begin
            if (pop) void'(q.pop_front());
            if (push) q.push_back(pdata);
        end
        if (finish) m_done = 1;
        else if (reg_wr && reg_addr == 2'd3 && reg_wdata[31]) m_done = 0;
        if (reg_wr && reg_addr == 2'd1 && m_run == 0) m_total = int'(reg_wdata[13:0]);
        if (reg_wr && reg_addr == 2'd0 && m_run == 0) begin
            m_cs = int'(reg_wdata[26:24]); m_thr = int'(reg_wdata[14:8]);
            m_en = int'(reg_wdata[7]); m_dma = int'(reg_wdata[2]); m_dir = int'(reg_wdata[0]);
        end
        if (start_ok) begin
            m_run = 1; m_rem = m_total;
        end else if (stop_ok) begin
            m_run = 0; m_rem = 0;
            if (reg_wdata[1]) begin
                m_cs = 0; m_thr = 0; m_en = 0; m_dma = 0; m_dir = 0;
            end
        end else if (finish) m_run = 0;
        else if (xf) m_rem = m_rem - 1;
    endtask

    // model update at the edge, comparison two time units later
    always @(posedge clk) begin
        model_step();
        cyc++;
        #2;
        if (!rst) begin
            chk("R6 dev_req", 32'(dev_req), 32'(devreq_m()));
            chk("R7 dev_we", 32'(dev_we), 32'(m_dir));
            chk("R1 dev_cs", 32'(dev_cs), 32'(m_cs));
            chk("R8 R9 dma_req", 32'(dma_req), 32'(want_m() && m_dma != 0));
            chk("R8 R9 cpu_irq", 32'(cpu_irq), 32'(want_m() && m_dma == 0));
            chk("R5 reg_rdata", reg_rdata, rdata_m(reg_addr));
            if (m_dir == 0 && q.size() != 0) chk("R6 host_rdata", 32'(host_rdata), 32'(q[0]));
            if (m_dir != 0 && devreq_m()) chk("R7 dev_wdata", 32'(dev_wdata), 32'(q[0]));
        end
        if (cyc > 100000) begin
            bad_checks++;
            total_checks++;
            $display("FAIL watchdog R10: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
            $finish;
        end
    end

    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        dev_ack   = ack_en && lfsr[0];
        dev_rdata = lfsr[15:8];
    end

    function automatic logic [31:0] setup_w(input int cs, input int thr, input int en,
                                            input int dma, input int dir);
        return (cs << 24) | (thr << 8) | (en << 7) | (dma << 2) | dir;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd3;
    endtask

    task automatic look(input logic [1:0] a, input int n);
        @(negedge clk);
        reg_addr = a;
        repeat (n) @(negedge clk);
        reg_addr = 2'd3;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R5: reset state
        phase = "R5";
        repeat (3) @(negedge clk);

        // R1: field layout and readback
        phase = "R1";
        wr(2'd0, setup_w(5, 16, 1, 1, 0));
        wr(2'd1, 32'd40);
        look(2'd0, 2);
        look(2'd1, 2);

        // R3: start refused without enable, then accepted
        phase = "R3";
        wr(2'd0, setup_w(5, 16, 0, 1, 0));
        wr(2'd2, 32'd1);
        look(2'd2, 2);
        wr(2'd0, setup_w(5, 16, 1, 1, 0));
        ack_en = 1'b1;
        wr(2'd2, 32'd1);

        // R2: setup writes during a run are ignored
        phase = "R2";
        wr(2'd0, setup_w(1, 4, 1, 0, 1));
        wr(2'd1, 32'd7);
        look(2'd0, 2);

        // R6: prefetch drained by a DMA consumer
        phase = "R6";
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            host_pop = dma_req;
            if (m_done != 0 && q.size() == 0) break;
        end
        host_pop = 1'b0;

        // R10: sticky done, cleared by write-one
        phase = "R10";
        repeat (2) @(negedge clk);
        wr(2'd3, 32'h8000_0000);
        repeat (2) @(negedge clk);

        // R7: post-write fed by a CPU producer
        phase = "R7";
        wr(2'd0, setup_w(2, 8, 1, 0, 1));
        wr(2'd1, 32'd30);
        wr(2'd2, 32'd1);
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            host_push  = cpu_irq;
            host_wdata = lfsr[7:0] ^ 8'h5A;
            if (m_done != 0) break;
        end
        host_push = 1'b0;
        wr(2'd3, 32'h8000_0000);

        // R8: oversized threshold acts as 64, full FIFO holds off the device, tail request
        phase = "R8";
        wr(2'd0, setup_w(3, 100, 1, 1, 0));
        wr(2'd1, 32'd80);
        wr(2'd2, 32'd1);
        repeat (200) @(negedge clk);
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            host_pop = dma_req;
            if (m_done != 0 && q.size() == 0) break;
        end
        host_pop = 1'b0;
        wr(2'd3, 32'h8000_0000);

        // R11: pushes past full and pops in write direction are ignored
        phase = "R11";
        ack_en = 1'b0;
        wr(2'd0, setup_w(4, 8, 1, 0, 1));
        wr(2'd1, 32'd70);
        wr(2'd2, 32'd1);
        for (int i = 0; i < 70; i++) begin
            @(negedge clk);
            host_push  = 1'b1;
            host_wdata = 8'(i);
        end
        @(negedge clk);
        host_push = 1'b0;
        host_pop  = 1'b1;
        repeat (3) @(negedge clk);
        host_pop = 1'b0;

        // R4: stop naming another chip select is ignored, matching stop-and-clear works
        phase = "R4";
        wr(2'd2, 32'(3 << 24));
        look(2'd2, 2);
        wr(2'd2, 32'((4 << 24) | 2));
        look(2'd0, 2);
        repeat (2) @(negedge clk);

        // R11: pushes in read direction are ignored
        phase = "R11";
        wr(2'd0, setup_w(0, 8, 1, 1, 0));
        @(negedge clk);
        host_push = 1'b1;
        repeat (3) @(negedge clk);
        host_push = 1'b0;
        repeat (3) @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
        $finish;
    end

endmodule